// File: doc/BRIEF.md
# AVS Response Frame Checker

This block watches the serial input side of an adaptive voltage bus master. The response frame from the voltage regulator arrives one bit at a time, most significant bit first, and each bit comes with a bit-valid strobe. A frame-start strobe opens a new frame and a frame-end strobe closes it. While the bits arrive, the block runs a serial CRC over the payload and keeps the whole word.

When the frame ends, the block compares the computed CRC with the three trailing CRC bits and reads the two-bit status field at the top of the word. It then classifies the frame as good or as exactly one kind of error, using a fixed priority order. It also extracts the 16-bit read-data field. The results are registered and announced with a one-cycle done pulse. They stay on the outputs until the next frame-start strobe.

Top module: `avs_resp_checker`

## Requirements
- R1: Bits are taken MSB first, one per cycle in which `bit_vld_i` is high. The first bit lands in word bit 31. Valid bits after the 32nd in a frame are ignored.
- R2: The CRC is the remainder of the upper 29 word bits (31:3), multiplied by x^3, modulo x^3+x+1. It is compared against word bits 2:0. The CRC state starts from zero at each frame start.
- R3: `good_o` is set only when the status (word bits 31:30) is 0, the CRC matches, and the word is neither all zeros nor all ones.
- R4: An all-zero word sets `err_o[0]` (I/O disabled). This check comes before every other check.
- R5: An all-ones word sets `err_o[1]` (no slave answer). This check comes second.
- R6: A CRC mismatch sets `err_o[2]`. It takes precedence over any status-code error.
- R7: When the CRC matches, status 2 sets `err_o[3]` (slave saw a bad command CRC), status 1 sets `err_o[4]` (resource unavailable) and status 3 sets `err_o[5]` (unknown resource or invalid data). These are checked in that order.
- R8: `rdata_o` holds word bits 23:8 of the completed frame.
- R9: `done_o` is high for exactly one cycle, in the cycle after `frm_end_i`. The flags and read data are updated at that point and held until a `frm_start_i`, which clears them to zero one cycle later.
- R10: At most one bit of `err_o` is set. After a frame ends, exactly one of `good_o` and the error flags is set.
- R11: After reset, `done_o`, `good_o`, `err_o` and `rdata_o` are all zero.
- R12: A frame start discards any partly received frame, so the bits received before it have no effect on the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start_i | input | 1 | Opens a new frame; clears state and results |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial response bit, MSB first |
| frm_end_i | input | 1 | Closes the frame and triggers classification |
| done_o | output | 1 | One-cycle result strobe |
| good_o | output | 1 | Frame is a valid good response |
| err_o | output | 6 | One-hot error class |
| rdata_o | output | 16 | Read-data field of the last frame |

## Verification
The hardest case to reach is a frame that carries several faults at once. For example, a word can have a nonzero status and also a wrong CRC, or it can be all ones, which is status 3 with a CRC that does not match. Only such frames show that the priority order wins. The directed tasks build these words on purpose: they compute the correct CRC first and then flip the status or CRC bits. The bench also sends surplus bits after the 32nd and aborts a partial frame, to show that neither of them leaks into the next result.

// File: rtl/avs_rsp_pkg.sv
package avs_rsp_pkg;
   localparam int ERR_N = 6;
   typedef logic [ERR_N-1:0] err_vec_t;

   typedef enum int unsigned {
      ERR_ZERO  = 0,
      ERR_ONES  = 1,
      ERR_MCRC  = 2,
      ERR_SCRC  = 3,
      ERR_UNAV  = 4,
      ERR_INVAL = 5
   } err_idx_e;

   localparam logic [1:0] ST_OK    = 2'd0;
   localparam logic [1:0] ST_UNAV  = 2'd1;
   localparam logic [1:0] ST_SCRC  = 2'd2;
   localparam logic [1:0] ST_INVAL = 2'd3;
endpackage

// File: rtl/avs_rsp_crc.sv
module avs_rsp_crc #(
   parameter int               CRC_W = 3,
   parameter logic [CRC_W-1:0] POLY  = 3'b011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_d;
   logic             fb;

   assign fb = bit_i ^ crc_q[CRC_W-1];

   generate
      for (genvar i = 0; i < CRC_W; i++) begin : g_tap
         if (i == 0) begin : g_low
            assign crc_d[i] = POLY[i] & fb;
         end else begin : g_hi
            assign crc_d[i] = crc_q[i-1] ^ (POLY[i] & fb);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) crc_q <= '0;
      else if (en_i)       crc_q <= crc_d;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/avs_rsp_shift.sv
module avs_rsp_shift #(
   parameter int FRAME_W = 32,
   parameter int CRC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               vld_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] word_o,
   output logic               crc_en_o
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam int PAY_N = FRAME_W - CRC_W;

   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] word_q;
   logic               take;

   assign take     = vld_i && (cnt_q != CNT_W'(FRAME_W));
   assign crc_en_o = take && (cnt_q < CNT_W'(PAY_N));

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q  <= '0;
         word_q <= '0;
      end else if (take) begin
         cnt_q  <= cnt_q + 1'b1;
         word_q <= {word_q[FRAME_W-2:0], bit_i};
      end
   end

   assign word_o = word_q;
endmodule

// File: rtl/avs_rsp_classify.sv
module avs_rsp_classify
   import avs_rsp_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int CRC_W    = 3,
   parameter int DATA_W   = 16,
   parameter int DATA_LSB = 8
) (
   input  logic [FRAME_W-1:0] word_i,
   input  logic [CRC_W-1:0]   crc_i,
   output logic               good_o,
   output err_vec_t           err_o,
   output logic [DATA_W-1:0]  rdata_o
);
   logic [1:0] status;
   logic       all_z, all_o, crc_bad;

   assign status  = word_i[FRAME_W-1 -: 2];
   assign all_z   = ~|word_i;
   assign all_o   = &word_i;
   assign crc_bad = word_i[CRC_W-1:0] != crc_i;
   assign rdata_o = word_i[DATA_LSB +: DATA_W];

   always_comb begin
      err_o  = '0;
      good_o = 1'b0;
      if (all_z)                  err_o[ERR_ZERO]  = 1'b1;
      else if (all_o)             err_o[ERR_ONES]  = 1'b1;
      else if (crc_bad)           err_o[ERR_MCRC]  = 1'b1;
      else if (status == ST_SCRC) err_o[ERR_SCRC]  = 1'b1;
      else if (status == ST_UNAV) err_o[ERR_UNAV]  = 1'b1;
      else if (status == ST_INVAL) err_o[ERR_INVAL] = 1'b1;
      else                        good_o = 1'b1;
   end
endmodule

// File: rtl/avs_resp_checker.sv
module avs_resp_checker
   import avs_rsp_pkg::*;
#(
   parameter int               FRAME_W  = 32,
   parameter int               CRC_W    = 3,
   parameter logic [CRC_W-1:0] CRC_POLY = 3'b011,
   parameter int               DATA_W   = 16,
   parameter int               DATA_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              frm_end_i,
   output logic              done_o,
   output logic              good_o,
   output logic [ERR_N-1:0]  err_o,
   output logic [DATA_W-1:0] rdata_o
);
   generate
      if (FRAME_W < CRC_W + 3) begin : g_bad_frame
         $error("FRAME_W too small for status and CRC");
      end
      if (DATA_LSB + DATA_W > FRAME_W - 2) begin : g_bad_data
         $error("read-data field overlaps status field");
      end
      if (DATA_LSB < CRC_W) begin : g_bad_lsb
         $error("read-data field overlaps CRC field");
      end
   endgenerate

   logic [FRAME_W-1:0] word;
   logic               crc_en;
   logic [CRC_W-1:0]   crc_calc;
   logic               good_c;
   err_vec_t           err_c;
   logic [DATA_W-1:0]  rdata_c;

   avs_rsp_shift #(.FRAME_W(FRAME_W), .CRC_W(CRC_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (frm_start_i),
      .vld_i    (bit_vld_i),
      .bit_i    (bit_i),
      .word_o   (word),
      .crc_en_o (crc_en)
   );

   avs_rsp_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (frm_start_i),
      .en_i  (crc_en),
      .bit_i (bit_i),
      .crc_o (crc_calc)
   );

   avs_rsp_classify #(
      .FRAME_W(FRAME_W), .CRC_W(CRC_W), .DATA_W(DATA_W), .DATA_LSB(DATA_LSB)
   ) u_cls (
      .word_i  (word),
      .crc_i   (crc_calc),
      .good_o  (good_c),
      .err_o   (err_c),
      .rdata_o (rdata_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || frm_start_i) begin
         done_o  <= 1'b0;
         good_o  <= 1'b0;
         err_o   <= '0;
         rdata_o <= '0;
      end else if (frm_end_i) begin
         done_o  <= 1'b1;
         good_o  <= good_c;
         err_o   <= err_c;
         rdata_o <= rdata_c;
      end else begin
         done_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/avs_rsp_chk.sv
module avs_rsp_chk #(
   parameter int ERR_W = 6,
   parameter int DW    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_start_i,
   input logic             frm_end_i,
   input logic             done_o,
   input logic             good_o,
   input logic [ERR_W-1:0] err_o,
   input logic [DW-1:0]    rdata_o
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R9
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_end_i && !frm_start_i) |=> done_o);
   // R9
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start_i |=> (!good_o && err_o == '0 && rdata_o == '0 && !done_o));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_start_i && !frm_end_i) |=> ($stable(good_o) && $stable(err_o) && $stable(rdata_o)));
   // R10
   err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(err_o));
   // R10
   exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones({good_o, err_o}) == 1));
endmodule

bind avs_resp_checker avs_rsp_chk #(.ERR_W(avs_rsp_pkg::ERR_N), .DW(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_start_i(frm_start_i), .frm_end_i(frm_end_i),
   .done_o(done_o), .good_o(good_o), .err_o(err_o), .rdata_o(rdata_o)
);

// File: tb/tb_avs_resp_checker.sv
module tb_avs_resp_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, frm_end_i = 1'b0;
   logic        done_o, good_o;
   logic [5:0]  err_o;
   logic [15:0] rdata_o;
   int          n_run = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   avs_resp_checker dut (
      .clk(clk), .rst_n(rst_n), .frm_start_i(frm_start_i), .bit_vld_i(bit_vld_i),
      .bit_i(bit_i), .frm_end_i(frm_end_i), .done_o(done_o), .good_o(good_o),
      .err_o(err_o), .rdata_o(rdata_o)
   );

   function automatic logic [2:0] ref_crc(logic [31:0] w);
      logic [31:0] r;
      r = {w[31:3], 3'b000};
      for (int i = 31; i >= 3; i--) if (r[i]) r[i -: 4] = r[i -: 4] ^ 4'b1011;
      return r[2:0];
   endfunction

   function automatic logic [31:0] seal(logic [31:0] w);
      return {w[31:3], ref_crc(w)};
   endfunction

   function automatic logic [6:0] ref_cls(logic [31:0] w);
      if (w == 32'h0)                 return 7'b0_000001;
      if (w == 32'hFFFF_FFFF)         return 7'b0_000010;
      if (w[2:0] != ref_crc(w))       return 7'b0_000100;
      if (w[31:30] == 2'd2)           return 7'b0_001000;
      if (w[31:30] == 2'd1)           return 7'b0_010000;
      if (w[31:30] == 2'd3)           return 7'b0_100000;
      return 7'b1_000000;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic start_pulse();
      @(negedge clk) frm_start_i = 1'b1;
      @(negedge clk) frm_start_i = 1'b0;
   endtask

   task automatic send_bits(logic [31:0] w, int n);
      for (int i = 31; i > 31 - n; i--) begin
         bit_vld_i = 1'b1;
         bit_i = w[i];
         @(negedge clk);
      end
      bit_vld_i = 1'b0;
   endtask

   task automatic end_frame();
      frm_end_i = 1'b1;
      @(negedge clk) frm_end_i = 1'b0;
   endtask

   task automatic run_frame(string req, logic [31:0] w);
      start_pulse();
      send_bits(w, 32);
      end_frame();
      chk({req, " done"}, {31'b0, done_o}, 32'd1);
      chk({req, " class"}, {25'b0, good_o, err_o}, {25'b0, ref_cls(w)});
      chk({req, " rdata"}, {16'b0, rdata_o}, {16'b0, w[23:8]});
   endtask

   task automatic t_reset();
      chk("R11 reset", {8'b0, done_o, good_o, err_o, rdata_o}, 32'd0);
   endtask

   task automatic t_good();
      logic [6:0] cls;
      run_frame("R3 R8 good", seal(32'h0012_3400));
      chk("R3 good flag", {31'b0, good_o}, 32'd1);
      cls = {good_o, err_o};
      @(negedge clk);
      chk("R9 done pulse", {31'b0, done_o}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R9 hold", {25'b0, good_o, err_o}, {25'b0, cls});
      chk("R9 hold rdata", {16'b0, rdata_o}, 32'h1234);
      start_pulse();
      chk("R9 start clears", {8'b0, done_o, good_o, err_o, rdata_o}, 32'd0);
   endtask

   task automatic t_zero_ones();
      run_frame("R4 all zero", 32'h0);
      chk("R4 flag", {26'b0, err_o}, 32'h01);
      run_frame("R5 all ones", 32'hFFFF_FFFF);
      chk("R5 flag", {26'b0, err_o}, 32'h02);
   endtask

   task automatic t_crc();
      logic [31:0] w;
      w = seal(32'h00BE_EF00);
      run_frame("R2 flip data bit", w ^ 32'h0000_0100);
      chk("R2 mismatch", {26'b0, err_o}, 32'h04);
      run_frame("R2 flip crc bit", w ^ 32'h1);
      chk("R2 mismatch crc", {26'b0, err_o}, 32'h04);
      w = seal(32'h8055_AA00) ^ 32'h2;
      run_frame("R6 crc over status", w);
      chk("R6 priority", {26'b0, err_o}, 32'h04);
      run_frame("R2 match nonzero", seal(32'h3A5C_F0F8));
      chk("R2 match good", {31'b0, good_o}, 32'd1);
   endtask

   task automatic t_status();
      run_frame("R7 status2", seal(32'h80AB_CD00));
      chk("R7 s2 flag", {26'b0, err_o}, 32'h08);
      run_frame("R7 status1", seal(32'h40AB_CD00));
      chk("R7 s1 flag", {26'b0, err_o}, 32'h10);
      run_frame("R7 status3", seal(32'hC0AB_CD00));
      chk("R7 s3 flag", {26'b0, err_o}, 32'h20);
   endtask

   task automatic t_extra_bits();
      logic [31:0] w;
      w = seal(32'h0077_1100);
      start_pulse();
      send_bits(w, 32);
      send_bits(32'hFFFF_FFFF, 5);
      end_frame();
      chk("R1 extra ignored", {25'b0, good_o, err_o}, 32'h40);
      chk("R1 rdata", {16'b0, rdata_o}, 32'h7711);
   endtask

   task automatic t_abort();
      start_pulse();
      send_bits(32'hFFFF_FFFF, 11);
      run_frame("R12 restart", seal(32'h0042_4200));
      chk("R12 good after abort", {31'b0, good_o}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_zero_ones();
      t_crc();
      t_status();
      t_extra_bits();
      t_abort();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule